// File: doc/BRIEF.md
# Block Transfer Byte Packer

This block sits between a 16-bit word buffer and an 8-bit card data stream. It moves one byte per clock at most, using a valid/ready handshake on the byte side. When receiving, it packs incoming bytes into words, filling bits 7:0 first. When transmitting, it splits buffered words into bytes, sending the low byte first. Two counters track the data. One counts the bytes left in the current block. The other counts the blocks left in the transfer. When both run out, the transfer ends and a sticky done flag is raised.

Software-side logic writes two fields: the block length and the block count. Each stores the written value plus one. Issuing a start then clears the buffer and latches the direction. The host side reads or writes whole words of the internal buffer. Receiving stops while the buffer is fuller than a programmable almost-full level. Transmitting stops while the buffer is empty. Both resume on their own.

Top module: `blk_byte_packer`

## Requirements
- R1: After reset the buffer is empty, busy and done are low, rx_ready_o and tx_valid_o are low, and both counters read 1.
- R2: A write with cfg_sel_i=0 stores length = value+1 and loads the byte counter with it. A write with cfg_sel_i=1 stores count = value+1, loads the block counter with it and reloads the byte counter from the stored length. The 11-bit value gives 1 to 2048, and neither counter ever reads 0.
- R3: In receive, the first byte of a word lands in bits 7:0 and the second in bits 15:8. A block of odd length ends with a word whose bits 15:8 are zero, and the next block starts a fresh word.
- R4: In transmit, each word sends bits 7:0 first and then bits 15:8. The high byte is skipped and the word is dropped when the low byte was the last byte of the block.
- R5: rx_ready_o is low whenever the buffer level exceeds af_level_i.
- R6: tx_valid_o is low whenever the buffer is empty.
- R7: Each accepted byte decrements the byte counter. When a byte ends a block, the block counter decrements and the byte counter reloads the stored length.
- R8: The byte that ends the last block reloads both counters, drops busy_o and sets done_o. done_o then stays set until done_clr_i is pulsed.
- R9: start_i empties the buffer and raises busy_o. start_rx_i=1 selects receive and 0 selects transmit.
- R10: No byte moves while idle, and receive and transmit are never offered in the same cycle.
- R11: Host word writes are dropped when the buffer is full or a receive is running. Host reads pop the head word unless the buffer is empty or a transmit is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cfg_wr_i | input | 1 | Write a configuration field |
| cfg_sel_i | input | 1 | 0 selects block length, 1 selects block count |
| cfg_val_i | input | 11 | Field value; the stored value is this plus one |
| start_i | input | 1 | Start a data transfer |
| start_rx_i | input | 1 | Direction for start: 1 receive, 0 transmit |
| af_level_i | input | 5 | Almost-full level for receive |
| host_wr_i | input | 1 | Push a word into the buffer |
| host_wdata_i | input | 16 | Word to push |
| host_rd_i | input | 1 | Pop the head word |
| host_rdata_o | output | 16 | Head word of the buffer |
| level_o | output | 6 | Words in the buffer |
| rx_valid_i | input | 1 | Card byte valid |
| rx_data_i | input | 8 | Card byte |
| rx_ready_o | output | 1 | Block accepts a card byte |
| tx_valid_o | output | 1 | Block offers a byte to the card |
| tx_data_o | output | 8 | Byte to the card |
| tx_ready_i | input | 1 | Card accepts the byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky transfer-complete flag |
| done_clr_i | input | 1 | Clear done_o |
| bytes_left_o | output | 12 | Byte counter |
| blocks_left_o | output | 12 | Block counter |

## Verification
Suppose the half-word flag is wrong. In receive, the very next word popped has its bytes in the wrong lanes. In transmit, the next byte sent comes from the wrong lane or a word is skipped. Either shows within one word. A byte counter that is off by one moves a block boundary. That shows up as a misplaced zero-padded half word or a missed high byte. busy_o and done_o also change on the wrong cycle, so the mismatch appears by the end of the first block. A buffer level that goes wrong shows at level_o and in the stall points of the handshakes as soon as the almost-full level or empty is reached.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  active;
        logic  rx_dir;
        logic  half;
        byte_t low;
        logic  done;
    } ctl_t;
endpackage

// File: rtl/bbp_word_fifo.sv
module bbp_word_fifo
    import bbp_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned LW = AW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          push_i,
    input  word_t         wdata_i,
    input  logic          pop_i,
    output word_t         rdata_o,
    output logic [LW-1:0] level_o
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [LW-1:0] lvl;
    } fst_t;

    fst_t  st_d, st_q;
    word_t mem [DEPTH];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (push_i) st_d.wr = nxt(st_q.wr);
            if (pop_i)  st_d.rd = nxt(st_q.rd);
            st_d.lvl = st_q.lvl + LW'(push_i) - LW'(pop_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_i && !clr_i) mem[st_q.wr] <= wdata_i;
    end

    assign rdata_o = mem[st_q.rd];
    assign level_o = st_q.lvl;
endmodule

// File: rtl/bbp_xfer_count.sv
module bbp_xfer_count #(
    parameter int unsigned LEN_W = 11,
    localparam int unsigned CW = LEN_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic             cfg_sel_i,
    input  logic [LEN_W-1:0] cfg_val_i,
    input  logic             step_i,
    output logic [CW-1:0]    bytes_left_o,
    output logic [CW-1:0]    blocks_left_o,
    output logic             last_byte_o,
    output logic             last_xfer_o
);
    typedef struct packed {
        logic [CW-1:0] len;
        logic [CW-1:0] cnt;
        logic [CW-1:0] bytes;
        logic [CW-1:0] blocks;
    } cst_t;

    cst_t          st_d, st_q;
    logic [CW-1:0] wval;

    assign wval        = CW'(cfg_val_i) + CW'(1);
    assign last_byte_o = (st_q.bytes == CW'(1));
    assign last_xfer_o = last_byte_o && (st_q.blocks == CW'(1));

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (last_byte_o) begin
                st_d.bytes  = st_q.len;
                st_d.blocks = (st_q.blocks == CW'(1)) ? st_q.cnt : st_q.blocks - CW'(1);
            end else begin
                st_d.bytes = st_q.bytes - CW'(1);
            end
        end
        if (cfg_wr_i) begin
            if (!cfg_sel_i) begin
                st_d.len   = wval;
                st_d.bytes = wval;
            end else begin
                st_d.cnt    = wval;
                st_d.blocks = wval;
                st_d.bytes  = st_q.len;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{len: CW'(1), cnt: CW'(1), bytes: CW'(1), blocks: CW'(1)};
        else         st_q <= st_d;
    end

    assign bytes_left_o  = st_q.bytes;
    assign blocks_left_o = st_q.blocks;
endmodule

// File: rtl/blk_byte_packer.sv
module blk_byte_packer
    import bbp_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LEN_W = 11,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned LW = AW + 1,
    localparam int unsigned CW = LEN_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic             cfg_sel_i,
    input  logic [LEN_W-1:0] cfg_val_i,
    input  logic             start_i,
    input  logic             start_rx_i,
    input  logic [AW-1:0]    af_level_i,
    input  logic             host_wr_i,
    input  logic [15:0]      host_wdata_i,
    input  logic             host_rd_i,
    output logic [15:0]      host_rdata_o,
    output logic [LW-1:0]    level_o,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_data_i,
    output logic             rx_ready_o,
    output logic             tx_valid_o,
    output logic [7:0]       tx_data_o,
    input  logic             tx_ready_i,
    output logic             busy_o,
    output logic             done_o,
    input  logic             done_clr_i,
    output logic [CW-1:0]    bytes_left_o,
    output logic [CW-1:0]    blocks_left_o
);
    ctl_t          ctl_d, ctl_q;
    word_t         head, eng_word;
    logic [LW-1:0] level;
    logic          eng_push, eng_pop, host_push, host_pop;
    logic          rx_acc, tx_acc, last_byte, last_xfer;

    assign rx_ready_o = ctl_q.active && ctl_q.rx_dir && !start_i &&
                        (level <= {1'b0, af_level_i}) && (level < LW'(DEPTH));
    assign tx_valid_o = ctl_q.active && !ctl_q.rx_dir && !start_i && (level != '0);
    assign tx_data_o  = ctl_q.half ? head[WORD_W-1:BYTE_W] : head[BYTE_W-1:0];
    assign rx_acc     = rx_valid_i && rx_ready_o;
    assign tx_acc     = tx_valid_o && tx_ready_i;

    assign host_push  = host_wr_i && (level < LW'(DEPTH)) && !(ctl_q.active && ctl_q.rx_dir);
    assign host_pop   = host_rd_i && (level != '0) && !(ctl_q.active && !ctl_q.rx_dir);

    always_comb begin
        ctl_d    = ctl_q;
        eng_push = 1'b0;
        eng_pop  = 1'b0;
        eng_word = '0;
        if (rx_acc) begin
            if (!ctl_q.half) begin
                if (last_byte) begin
                    eng_push = 1'b1;
                    eng_word = {{BYTE_W{1'b0}}, rx_data_i};
                end else begin
                    ctl_d.low  = rx_data_i;
                    ctl_d.half = 1'b1;
                end
            end else begin
                eng_push   = 1'b1;
                eng_word   = {rx_data_i, ctl_q.low};
                ctl_d.half = 1'b0;
            end
        end
        if (tx_acc) begin
            if (!ctl_q.half && !last_byte) begin
                ctl_d.half = 1'b1;
            end else begin
                eng_pop    = 1'b1;
                ctl_d.half = 1'b0;
            end
        end
        if (done_clr_i) ctl_d.done = 1'b0;
        if ((rx_acc || tx_acc) && last_xfer) begin
            ctl_d.active = 1'b0;
            ctl_d.done   = 1'b1;
        end
        if (start_i) begin
            ctl_d.active = 1'b1;
            ctl_d.rx_dir = start_rx_i;
            ctl_d.half   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    bbp_word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (start_i),
        .push_i  (eng_push || host_push),
        .wdata_i (eng_push ? eng_word : host_wdata_i),
        .pop_i   (eng_pop || host_pop),
        .rdata_o (head),
        .level_o (level)
    );

    bbp_xfer_count #(.LEN_W(LEN_W)) u_count (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .cfg_wr_i      (cfg_wr_i),
        .cfg_sel_i     (cfg_sel_i),
        .cfg_val_i     (cfg_val_i),
        .step_i        (rx_acc || tx_acc),
        .bytes_left_o  (bytes_left_o),
        .blocks_left_o (blocks_left_o),
        .last_byte_o   (last_byte),
        .last_xfer_o   (last_xfer)
    );

    assign host_rdata_o = head;
    assign level_o      = level;
    assign busy_o       = ctl_q.active;
    assign done_o       = ctl_q.done;
endmodule

// File: rtl/bbp_checker.sv
module bbp_checker #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LEN_W = 11,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned LW = AW + 1,
    localparam int unsigned CW = LEN_W + 1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          cfg_wr_i,
    input logic          start_i,
    input logic [AW-1:0] af_level_i,
    input logic [LW-1:0] level_o,
    input logic          rx_valid_i,
    input logic          rx_ready_o,
    input logic          tx_valid_o,
    input logic          tx_ready_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          done_clr_i,
    input logic [CW-1:0] bytes_left_o,
    input logic [CW-1:0] blocks_left_o
);
    p_counts_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bytes_left_o != '0 && blocks_left_o != '0);

    p_rx_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_ready_o |-> level_o <= {1'b0, af_level_i});

    p_tx_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_valid_o |-> level_o != '0);

    p_byte_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rx_valid_i && rx_ready_o) || (tx_valid_o && tx_ready_i)) &&
        bytes_left_o > CW'(1) && !cfg_wr_i
        |=> bytes_left_o == $past(bytes_left_o) - CW'(1));

    p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !done_clr_i |=> done_o);

    p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> level_o == '0 && busy_o);

    p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !rx_ready_o && !tx_valid_o);

    p_one_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rx_ready_o && tx_valid_o));

    p_level_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= LW'(DEPTH));
endmodule

bind blk_byte_packer bbp_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/blk_byte_packer_tb_top.sv
`timescale 1ns/1ps
module blk_byte_packer_tb_top;
    localparam int DEPTH = 32;
    localparam int LEN_W = 11;
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;
    localparam int CW = LEN_W + 1;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             cfg_wr_i = 1'b0, cfg_sel_i = 1'b0;
    logic [LEN_W-1:0] cfg_val_i = '0;
    logic             start_i = 1'b0, start_rx_i = 1'b0;
    logic [AW-1:0]    af_level_i = '1;
    logic             host_wr_i = 1'b0, host_rd_i = 1'b0;
    logic [15:0]      host_wdata_i = '0, host_rdata_o;
    logic [LW-1:0]    level_o;
    logic             rx_valid_i = 1'b0, rx_ready_o;
    logic [7:0]       rx_data_i = '0, tx_data_o;
    logic             tx_valid_o, tx_ready_i = 1'b0;
    logic             busy_o, done_o, done_clr_i = 1'b0;
    logic [CW-1:0]    bytes_left_o, blocks_left_o;

    always #2.5 clk_i = ~clk_i;

    blk_byte_packer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut_i (.*);

    int          n_chk = 0, n_bad = 0;
    bit          ended = 0;
    logic [15:0] exp_words[$];
    logic [7:0]  exp_bytes[$];
    logic [15:0] tw[8];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: host word pops (R3, R11)
    always @(negedge clk_i) begin
        if (rst_ni && host_rd_i && level_o != '0) begin
            if (exp_words.size() == 0) chk(0, "R3 word pop with empty queue", host_rdata_o, 0);
            else begin
                logic [15:0] e;
                e = exp_words.pop_front();
                chk(host_rdata_o == e, "R3 word", host_rdata_o, e);
            end
        end
    end

    // Monitor: card bytes sent (R4)
    always @(negedge clk_i) begin
        if (rst_ni && tx_valid_o && tx_ready_i) begin
            if (exp_bytes.size() == 0) chk(0, "R4 byte with empty queue", tx_data_o, 0);
            else begin
                logic [7:0] e;
                e = exp_bytes.pop_front();
                chk(tx_data_o == e, "R4 byte", tx_data_o, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic cfg(input bit sel, input int val);
        cfg_wr_i = 1; cfg_sel_i = sel; cfg_val_i = LEN_W'(val);
        @(posedge clk_i); #1; cfg_wr_i = 0;
    endtask

    task automatic start_xfer(input bit rx);
        start_i = 1; start_rx_i = rx;
        @(posedge clk_i); #1; start_i = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid_i = 1; rx_data_i = b;
        do @(negedge clk_i); while (!rx_ready_o);
        @(posedge clk_i); #1; rx_valid_i = 0;
    endtask

    task automatic host_read();
        host_rd_i = 1; @(posedge clk_i); #1; host_rd_i = 0;
    endtask

    task automatic host_write(input logic [15:0] w);
        host_wr_i = 1; host_wdata_i = w; @(posedge clk_i); #1; host_wr_i = 0;
    endtask

    task automatic model_rx(input int len, input int nblk, input int base);
        int k = 0;
        logic [7:0] lo = '0;
        for (int b = 0; b < nblk; b++)
            for (int i = 0; i < len; i++) begin
                logic [7:0] v;
                v = 8'(base + k);
                k++;
                if (i % 2 == 0) begin
                    if (i == len - 1) exp_words.push_back({8'h00, v});
                    else lo = v;
                end else exp_words.push_back({v, lo});
            end
    endtask

    task automatic model_tx(input int len, input int nblk);
        int wi = 0;
        for (int b = 0; b < nblk; b++)
            for (int i = 0; i < len; i++) begin
                if (i % 2 == 0) begin
                    exp_bytes.push_back(tw[wi][7:0]);
                    if (i == len - 1) wi++;
                end else begin
                    exp_bytes.push_back(tw[wi][15:8]);
                    wi++;
                end
            end
    endtask

    initial begin
        repeat (3) @(posedge clk_i);
        #1; rst_ni = 1;
        @(posedge clk_i); #1;

        // R1 reset state
        chk(level_o == 0 && !busy_o && !done_o, "R1 idle", {level_o, busy_o, done_o}, 0);
        chk(!rx_ready_o && !tx_valid_o, "R1 handshakes", {rx_ready_o, tx_valid_o}, 0);
        chk(bytes_left_o == 1 && blocks_left_o == 1, "R1 counters", {bytes_left_o, blocks_left_o}, 'h001001);

        // R2 configuration
        cfg(0, 2047);
        chk(bytes_left_o == 2048, "R2 max length", bytes_left_o, 2048);
        cfg(0, 4);
        chk(bytes_left_o == 5, "R2 length load", bytes_left_o, 5);
        cfg(1, 1);
        chk(blocks_left_o == 2 && bytes_left_o == 5, "R2 count load", {bytes_left_o, blocks_left_o}, 'h005002);

        // R3 / R7 / R8 / R9 receive, odd blocks
        start_xfer(1);
        chk(busy_o && level_o == 0, "R9 start rx", {busy_o, level_o}, 'h40);
        model_rx(5, 2, 'hA0);
        for (int k = 0; k < 3; k++) send_byte(8'(8'hA0 + k));
        chk(bytes_left_o == 2 && blocks_left_o == 2, "R7 byte step", {bytes_left_o, blocks_left_o}, 'h002002);
        for (int k = 3; k < 5; k++) send_byte(8'(8'hA0 + k));
        chk(bytes_left_o == 5 && blocks_left_o == 1, "R7 block step", {bytes_left_o, blocks_left_o}, 'h005001);
        for (int k = 5; k < 10; k++) send_byte(8'(8'hA0 + k));
        chk(!busy_o && done_o, "R8 end flags", {busy_o, done_o}, 1);
        chk(bytes_left_o == 5 && blocks_left_o == 2, "R8 reload", {bytes_left_o, blocks_left_o}, 'h005002);
        chk(level_o == 6, "R3 word count", level_o, 6);
        repeat (6) host_read();
        chk(level_o == 0, "R3 drained", level_o, 0);

        // R8 done clear
        done_clr_i = 1; @(posedge clk_i); #1; done_clr_i = 0;
        chk(!done_o, "R8 clear", done_o, 0);

        // R5 almost-full stall
        af_level_i = 2;
        cfg(0, 9); cfg(1, 0);
        start_xfer(1);
        model_rx(10, 1, 'h10);
        for (int k = 0; k < 6; k++) send_byte(8'(8'h10 + k));
        rx_valid_i = 1; rx_data_i = 8'h16;
        @(negedge clk_i);
        chk(!rx_ready_o && level_o == 3, "R5 stall", {rx_ready_o, level_o}, 3);
        @(posedge clk_i); #1; rx_valid_i = 0;
        host_read();
        send_byte(8'h16); send_byte(8'h17);
        host_read();
        send_byte(8'h18); send_byte(8'h19);
        chk(done_o && !busy_o, "R8 rx stall end", {done_o, busy_o}, 2);
        repeat (3) host_read();
        af_level_i = '1;
        done_clr_i = 1; @(posedge clk_i); #1; done_clr_i = 0;

        // R4 / R6 transmit
        cfg(0, 2); cfg(1, 1);
        start_xfer(0);
        @(negedge clk_i);
        chk(!tx_valid_o && busy_o, "R6 empty pause", {tx_valid_o, busy_o}, 1);
        @(posedge clk_i); #1;
        tw[0] = 16'h1122; tw[1] = 16'h3344; tw[2] = 16'h5566; tw[3] = 16'h7788;
        model_tx(3, 2);
        tx_ready_i = 1;
        for (int w = 0; w < 4; w++) host_write(tw[w]);
        for (int t = 0; t < 100; t++) begin
            @(negedge clk_i);
            if (!busy_o) break;
        end
        @(posedge clk_i); #1;
        tx_ready_i = 0;
        chk(done_o && !busy_o && level_o == 0, "R4 tx end", {done_o, busy_o, level_o}, 'h80);
        chk(exp_bytes.size() == 0, "R4 all bytes sent", exp_bytes.size(), 0);

        // R9 start clears; R2 count write reloads byte counter mid-transfer
        for (int w = 0; w < 3; w++) host_write(16'hBEE0 + 16'(w));
        chk(level_o == 3, "R11 host write", level_o, 3);
        start_xfer(1);
        chk(level_o == 0 && busy_o, "R9 clears buffer", {level_o, busy_o}, 'h40);
        cfg(0, 6);
        exp_words.push_back(16'hC1C0);
        send_byte(8'hC0); send_byte(8'hC1);
        chk(bytes_left_o == 5, "R7 partial", bytes_left_o, 5);
        cfg(1, 0);
        chk(bytes_left_o == 7 && blocks_left_o == 1, "R2 count reload", {bytes_left_o, blocks_left_o}, 'h007001);
        model_rx(7, 1, 'hD0);
        for (int k = 0; k < 7; k++) send_byte(8'(8'hD0 + k));
        chk(!busy_o && level_o == 5, "R3 odd tail", {busy_o, level_o}, 5);
        repeat (5) host_read();

        // R11 full buffer drops host writes
        for (int w = 0; w < DEPTH; w++) begin
            host_write(16'h4000 + 16'(w));
            exp_words.push_back(16'h4000 + 16'(w));
        end
        chk(level_o == LW'(DEPTH), "R11 full", level_o, DEPTH);
        host_write(16'hDEAD);
        chk(level_o == LW'(DEPTH), "R11 write ignored", level_o, DEPTH);
        repeat (DEPTH) host_read();
        chk(level_o == 0 && exp_words.size() == 0, "R11 drained", level_o, 0);

        finish_run();
    end
endmodule